// File: doc/BRIEF.md
# Power-Driver Operating Mode Controller

This block is the operating-mode state machine of a four-channel power switch that is configured over a serial peripheral link. It tracks seven modes, decides which source drives the output stages in each of them, tells the serial front end whether it may accept frames, and tells the register file whether to clear or hold its contents. It reacts to a digital-supply-good flag, a battery-undervoltage flag, four direct input pins, the raw chip-select level, and a one-cycle strobe per received frame. Each strobe carries the decoded command byte and three control bits: unlock, stby and en.

A mode that hands more control to software is reached only through a two-frame handshake. The first frame arms the sequence with unlock set. The very next frame then names the target mode. Chip-select is watched in two ways. In Normal, a missing toggle within a time limit drops the block back to the safe mode. In the two low-power modes, a long low level on chip-select wakes the block. Battery undervoltage is handled as an overlay. It switches the outputs off and keeps the serial link alive, and when the condition clears the block resumes the mode it interrupted.

States and transitions:
- The states are Reset, FailSafe, Normal, Standby, Sleep1, Sleep2 and BattUV.
- Reset goes to Sleep1 when all direct inputs are low. Sleep1 goes back to Reset when any direct input is high.
- Reset and Sleep1 go to FailSafe when the supply becomes good.
- FailSafe goes to Normal after an unlock frame followed by a frame with stby=0 and en=1.
- FailSafe and Normal go to Standby after an unlock frame followed by a frame with stby=1 and en=0.
- Normal goes to FailSafe on an en=0 frame, on a soft-reset command, or on a toggle timeout.
- Standby goes to Sleep2 when all direct inputs are low. Sleep2 goes back to Standby when any direct input is high.
- Standby and Sleep2 go to FailSafe on a long chip-select low.
- Any mode except Reset and Sleep1 goes to BattUV while undervoltage is present, and returns to the saved mode afterwards.
- Any mode goes to Reset on supply loss.

Top module: `drv_mode_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the mode becomes Reset, rst_status is 0 and uv_status is 0.
- R2: When supply_ok is low, every mode other than Reset and Sleep1 becomes Reset one clock later. This includes BattUV.
- R3: With supply_ok low, Reset with din==0 becomes Sleep1, and Sleep1 with din!=0 becomes Reset. With supply_ok high, both Reset and Sleep1 become FailSafe one clock later.
- R4: FailSafe becomes Normal only when a frame with stby=0 and en=1 directly follows a frame with unlock=1. Such a frame with no unlock frame before it leaves the block in FailSafe.
- R5: An unlock frame arms the handshake for exactly the next frame. Any other frame in between disarms it without a mode change, so a later stby=1/en=0 frame does not reach Standby.
- R6: From FailSafe or Normal, an unlock frame followed directly by a frame with stby=1 and en=0 enters Standby.
- R7: In Normal, a frame with en=0 (and no armed standby request) or a frame with command byte 8'hFF moves the block to FailSafe. The 8'hFF command also pulses reg_clear high for one cycle and sets rst_status to 0.
- R8: In Normal, if no edge of the synchronized chip-select is seen for TOG_CYC consecutive cycles, the block moves to FailSafe. Any edge restarts the count.
- R9: In Standby or Sleep2, chip-select held low for WAKE_CYC synchronized cycles moves the block to FailSafe. A shorter low pulse has no effect. Standby with din==0 becomes Sleep2, and Sleep2 with din!=0 becomes Standby.
- R10: With supply_ok high, batt_uv high moves any mode other than Reset and Sleep1 to BattUV, where uv_status=1, drive is off and spi_en=1. When batt_uv falls, the interrupted mode returns one clock later and uv_status returns to 0.
- R11: The mode code is Reset=0, FailSafe=1, Normal=2, Standby=3, Sleep1=4, Sleep2=5, BattUV=6. The drv_src code is off=0, direct pins=1, serial settings with pins=2, assigned as follows:
  - Reset, FailSafe and Standby use 1; Normal uses 2; Sleep1, Sleep2 and BattUV use 0.
  - spi_en is 1 in FailSafe, Normal and BattUV.
  - reg_clear is 1 in Reset and Sleep1.
  - reg_freeze is 1 in Standby and Sleep2.
- R12: rst_status is 0 in Reset and Sleep1. It becomes 1 after the first accepted frame that is not 8'hFF.
- R13: Frames received in Standby, Sleep2 or BattUV, including 8'hFF, change neither the mode nor rst_status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Digital supply above its reset threshold |
| batt_uv | input | 1 | Battery supply below undervoltage threshold (hysteresis applied outside) |
| din | input | 4 | Direct input pins, one per channel |
| cs_n_raw | input | 1 | Asynchronous chip-select level |
| frame_vld | input | 1 | One-cycle strobe per received frame |
| frame_cmd | input | 8 | Command byte of the frame |
| frame_unlock | input | 1 | Unlock bit of the frame |
| frame_stby | input | 1 | Standby request bit of the frame |
| frame_en | input | 1 | Enable bit of the frame |
| mode | output | 3 | Current mode code (R11) |
| drv_src | output | 2 | Output-stage drive source code (R11) |
| spi_en | output | 1 | Serial front end may accept frames |
| reg_clear | output | 1 | Register file held in or pulsed to cleared state |
| reg_freeze | output | 1 | Register file contents frozen |
| rst_status | output | 1 | Global reset status bit |
| uv_status | output | 1 | Battery undervoltage status bit |

## Verification
A wrong state shows up on the mode port one clock after the input that caused it, and it changes drv_src, spi_en, reg_clear and reg_freeze in the same cycle, so the bench compares all of them together at every checkpoint. A lost or stale arm flag shows up as a mode that moves when it must not, or stays when it must move, on the frame right after the unlock frame. Counter faults show up as a mode change that is exactly one or more cycles early or late against the TOG_CYC and WAKE_CYC limits, so those windows are sampled on both sides of the expected edge. A bad saved mode in the overlay shows up as the wrong mode code one cycle after batt_uv falls.

// File: rtl/drv_mode_pkg.sv
package drv_mode_pkg;

    typedef enum logic [2:0] {
        MODE_RESET    = 3'd0,
        MODE_FAILSAFE = 3'd1,
        MODE_NORMAL   = 3'd2,
        MODE_STANDBY  = 3'd3,
        MODE_SLEEP1   = 3'd4,
        MODE_SLEEP2   = 3'd5,
        MODE_BATTUV   = 3'd6
    } mode_e;

    typedef enum logic [1:0] {
        DRV_OFF     = 2'd0,
        DRV_DIRECT  = 2'd1,
        DRV_SPI_MIX = 2'd2
    } drv_src_e;

    localparam logic [7:0] SOFT_RESET_CMD = 8'hFF;

endpackage

// File: rtl/drv_cs_watch.sv
module drv_cs_watch #(
    parameter int TOG_CYC  = 20000,
    parameter int WAKE_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_raw,
    input  logic watch_toggle,
    input  logic watch_low,
    output logic tog_expire,
    output logic wake_req
);
    localparam int TW = $clog2(TOG_CYC + 1);
    localparam int WW = $clog2(WAKE_CYC + 1);
    localparam logic [TW-1:0] TOG_LAST  = TW'(TOG_CYC - 1);
    localparam logic [WW-1:0] WAKE_LAST = WW'(WAKE_CYC - 1);

    logic          cs_s1, cs_s2, cs_d;
    logic          cs_edge;
    logic [TW-1:0] tog_cnt;
    logic [WW-1:0] low_cnt;

    // two-flop synchronizer plus one delay stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_s1 <= 1'b1;
            cs_s2 <= 1'b1;
            cs_d  <= 1'b1;
        end else begin
            cs_s1 <= cs_n_raw;
            cs_s2 <= cs_s1;
            cs_d  <= cs_s2;
        end
    end

    assign cs_edge = cs_s2 ^ cs_d;

    // toggle timer: restarts on any edge, idles outside Normal
    always_ff @(posedge clk) begin
        if (!rst_n || !watch_toggle || cs_edge) begin
            tog_cnt <= '0;
        end else if (tog_cnt != TOG_LAST) begin
            tog_cnt <= tog_cnt + 1'b1;
        end
    end

    assign tog_expire = watch_toggle && !cs_edge && (tog_cnt == TOG_LAST);

    // low-level timer: restarts whenever chip-select is high
    always_ff @(posedge clk) begin
        if (!rst_n || !watch_low || cs_s2) begin
            low_cnt <= '0;
        end else if (low_cnt != WAKE_LAST) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign wake_req = watch_low && !cs_s2 && (low_cnt == WAKE_LAST);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tog_cnt <= TOG_LAST);

    assert_wake_after_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> !$past(cs_s2));

endmodule

// File: rtl/drv_unlock_seq.sv
module drv_unlock_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic spi_live,
    input  logic soft_reset,
    input  logic frame_unlock,
    output logic armed
);
    // armed covers exactly the next accepted frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (accept) begin
            armed <= frame_unlock && !soft_reset;
        end else if (!spi_live) begin
            armed <= 1'b0;
        end
    end

    assert_arm_one_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        armed && accept && !frame_unlock |=> !armed);

endmodule

// File: rtl/drv_mode_fsm.sv
module drv_mode_fsm
    import drv_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       batt_uv,
    input  logic [3:0] din,
    input  logic       frame_vld,
    input  logic [7:0] frame_cmd,
    input  logic       frame_stby,
    input  logic       frame_en,
    input  logic       armed,
    input  logic       tog_expire,
    input  logic       wake_req,
    output logic       accept,
    output logic       soft_reset,
    output logic       spi_live,
    output logic       watch_toggle,
    output logic       watch_low,
    output mode_e      mode_q,
    output drv_src_e   drv_src,
    output logic       spi_en,
    output logic       reg_clear,
    output logic       reg_freeze,
    output logic       rst_status,
    output logic       uv_status
);
    mode_e mode_d, prev_q, prev_d;
    logic  soft_rst_q;
    logic  din_any;
    logic  go_normal, go_standby;

    assign din_any    = |din;
    assign spi_live   = (mode_q == MODE_FAILSAFE) || (mode_q == MODE_NORMAL);
    assign accept     = frame_vld && supply_ok && !batt_uv && spi_live;
    assign soft_reset = (frame_cmd == SOFT_RESET_CMD);
    assign go_normal  = armed && !frame_stby && frame_en;
    assign go_standby = armed && frame_stby && !frame_en;
    assign watch_toggle = (mode_q == MODE_NORMAL);
    assign watch_low    = (mode_q == MODE_STANDBY) || (mode_q == MODE_SLEEP2);

    // next-state logic
    always_comb begin
        mode_d = mode_q;
        prev_d = prev_q;
        if (!supply_ok) begin
            unique case (mode_q)
                MODE_RESET:  if (!din_any) mode_d = MODE_SLEEP1;
                MODE_SLEEP1: if (din_any)  mode_d = MODE_RESET;
                default:     mode_d = MODE_RESET;
            endcase
        end else if ((mode_q == MODE_RESET) || (mode_q == MODE_SLEEP1)) begin
            mode_d = MODE_FAILSAFE;
        end else if (batt_uv) begin
            if (mode_q != MODE_BATTUV) begin
                prev_d = mode_q;
                mode_d = MODE_BATTUV;
            end
        end else begin
            unique case (mode_q)
                MODE_BATTUV: mode_d = prev_q;
                MODE_FAILSAFE: begin
                    if (accept && !soft_reset) begin
                        if (go_normal)       mode_d = MODE_NORMAL;
                        else if (go_standby) mode_d = MODE_STANDBY;
                    end
                end
                MODE_NORMAL: begin
                    if (tog_expire) begin
                        mode_d = MODE_FAILSAFE;
                    end else if (accept) begin
                        if (soft_reset)      mode_d = MODE_FAILSAFE;
                        else if (go_standby) mode_d = MODE_STANDBY;
                        else if (!frame_en)  mode_d = MODE_FAILSAFE;
                    end
                end
                MODE_STANDBY: begin
                    if (wake_req)      mode_d = MODE_FAILSAFE;
                    else if (!din_any) mode_d = MODE_SLEEP2;
                end
                MODE_SLEEP2: begin
                    if (wake_req)     mode_d = MODE_FAILSAFE;
                    else if (din_any) mode_d = MODE_STANDBY;
                end
                default: mode_d = mode_q;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= MODE_RESET;
            prev_q     <= MODE_FAILSAFE;
            soft_rst_q <= 1'b0;
            rst_status <= 1'b0;
        end else begin
            mode_q     <= mode_d;
            prev_q     <= prev_d;
            soft_rst_q <= accept && soft_reset;
            if ((mode_d == MODE_RESET) || (mode_d == MODE_SLEEP1)) begin
                rst_status <= 1'b0;
            end else if (accept) begin
                rst_status <= !soft_reset;
            end
        end
    end

    // output decode
    always_comb begin
        drv_src    = DRV_OFF;
        spi_en     = 1'b0;
        reg_clear  = soft_rst_q;
        reg_freeze = 1'b0;
        uv_status  = 1'b0;
        unique case (mode_q)
            MODE_RESET: begin
                drv_src   = DRV_DIRECT;
                reg_clear = 1'b1;
            end
            MODE_FAILSAFE: begin
                drv_src = DRV_DIRECT;
                spi_en  = 1'b1;
            end
            MODE_NORMAL: begin
                drv_src = DRV_SPI_MIX;
                spi_en  = 1'b1;
            end
            MODE_STANDBY: begin
                drv_src    = DRV_DIRECT;
                reg_freeze = 1'b1;
            end
            MODE_SLEEP1: reg_clear  = 1'b1;
            MODE_SLEEP2: reg_freeze = 1'b1;
            MODE_BATTUV: begin
                spi_en    = 1'b1;
                uv_status = 1'b1;
            end
            default: drv_src = DRV_OFF;
        endcase
    end

    assert_supply_loss_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok && (mode_q != MODE_RESET) && (mode_q != MODE_SLEEP1)
        |=> mode_q == MODE_RESET);

    assert_normal_needs_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_FAILSAFE) && !(armed && accept) |=> mode_q != MODE_NORMAL);

    assert_softreset_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        accept && (frame_cmd == SOFT_RESET_CMD) |=> reg_clear && !rst_status);

    assert_timeout_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_NORMAL) && supply_ok && !batt_uv && tog_expire
        |=> mode_q == MODE_FAILSAFE);

    assert_uv_enter_R10: assert property (@(posedge clk) disable iff (!rst_n)
        supply_ok && batt_uv && (mode_q != MODE_RESET) && (mode_q != MODE_SLEEP1)
        |=> mode_q == MODE_BATTUV);

    assert_uv_return_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_BATTUV) && supply_ok && !batt_uv |=> mode_q == $past(prev_q));

endmodule

// File: rtl/drv_mode_ctrl.sv
module drv_mode_ctrl
    import drv_mode_pkg::*;
#(
    parameter int TOG_CYC  = 20000,
    parameter int WAKE_CYC = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       batt_uv,
    input  logic [3:0] din,
    input  logic       cs_n_raw,
    input  logic       frame_vld,
    input  logic [7:0] frame_cmd,
    input  logic       frame_unlock,
    input  logic       frame_stby,
    input  logic       frame_en,
    output logic [2:0] mode,
    output logic [1:0] drv_src,
    output logic       spi_en,
    output logic       reg_clear,
    output logic       reg_freeze,
    output logic       rst_status,
    output logic       uv_status
);
    logic     accept, soft_reset, spi_live, armed;
    logic     watch_toggle, watch_low, tog_expire, wake_req;
    mode_e    mode_q;
    drv_src_e drv_src_w;

    drv_cs_watch #(.TOG_CYC(TOG_CYC), .WAKE_CYC(WAKE_CYC)) u_cs_watch (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n_raw     (cs_n_raw),
        .watch_toggle (watch_toggle),
        .watch_low    (watch_low),
        .tog_expire   (tog_expire),
        .wake_req     (wake_req)
    );

    drv_unlock_seq u_unlock (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .spi_live     (spi_live),
        .soft_reset   (soft_reset),
        .frame_unlock (frame_unlock),
        .armed        (armed)
    );

    drv_mode_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_ok    (supply_ok),
        .batt_uv      (batt_uv),
        .din          (din),
        .frame_vld    (frame_vld),
        .frame_cmd    (frame_cmd),
        .frame_stby   (frame_stby),
        .frame_en     (frame_en),
        .armed        (armed),
        .tog_expire   (tog_expire),
        .wake_req     (wake_req),
        .accept       (accept),
        .soft_reset   (soft_reset),
        .spi_live     (spi_live),
        .watch_toggle (watch_toggle),
        .watch_low    (watch_low),
        .mode_q       (mode_q),
        .drv_src      (drv_src_w),
        .spi_en       (spi_en),
        .reg_clear    (reg_clear),
        .reg_freeze   (reg_freeze),
        .rst_status   (rst_status),
        .uv_status    (uv_status)
    );

    assign mode    = mode_q;
    assign drv_src = drv_src_w;

endmodule

// File: tb/test_drv_mode_ctrl.sv
module test_drv_mode_ctrl;
    localparam int TOG  = 40;
    localparam int WAKE = 16;

    localparam logic [2:0] M_RST = 3'd0, M_FS = 3'd1, M_NRM = 3'd2, M_STB = 3'd3,
                           M_SL1 = 3'd4, M_SL2 = 3'd5, M_UV = 3'd6;

    typedef struct {
        string      tag;
        logic [9:0] exp;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_ok = 1'b0;
    logic       batt_uv = 1'b0;
    logic [3:0] din = 4'd0;
    logic       cs_n_raw = 1'b1;
    logic       frame_vld = 1'b0;
    logic [7:0] frame_cmd = 8'd0;
    logic       frame_unlock = 1'b0;
    logic       frame_stby = 1'b0;
    logic       frame_en = 1'b0;
    logic [2:0] mode;
    logic [1:0] drv_src;
    logic       spi_en, reg_clear, reg_freeze, rst_status, uv_status;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    item_t sb_q[$];

    always #5 clk = ~clk;

    drv_mode_ctrl #(.TOG_CYC(TOG), .WAKE_CYC(WAKE)) i_drv_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .batt_uv(batt_uv),
        .din(din), .cs_n_raw(cs_n_raw), .frame_vld(frame_vld),
        .frame_cmd(frame_cmd), .frame_unlock(frame_unlock),
        .frame_stby(frame_stby), .frame_en(frame_en), .mode(mode),
        .drv_src(drv_src), .spi_en(spi_en), .reg_clear(reg_clear),
        .reg_freeze(reg_freeze), .rst_status(rst_status), .uv_status(uv_status)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // expected port vector from the R11 table
    task automatic expect_mode(input string tag, input logic [2:0] m,
                               input logic rst, input logic clr_pulse);
        item_t      it;
        logic [1:0] d;
        logic       s, c, f, u;
        d = (m == M_NRM) ? 2'd2 :
            ((m == M_RST) || (m == M_FS) || (m == M_STB)) ? 2'd1 : 2'd0;
        s = (m == M_FS) || (m == M_NRM) || (m == M_UV);
        c = (m == M_RST) || (m == M_SL1) || clr_pulse;
        f = (m == M_STB) || (m == M_SL2);
        u = (m == M_UV);
        it.tag = tag;
        it.exp = {m, d, s, c, f, rst, u};
        sb_q.push_back(it);
    endtask

    task automatic send(input logic [7:0] cmd, input logic unl,
                        input logic stb, input logic en);
        @(negedge clk);
        frame_vld = 1'b1; frame_cmd = cmd;
        frame_unlock = unl; frame_stby = stb; frame_en = en;
        @(negedge clk);
        frame_vld = 1'b0; frame_unlock = 1'b0; frame_stby = 1'b0;
        frame_en = 1'b0; frame_cmd = 8'd0;
    endtask

    // monitor: pops expectations and compares against the ports
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() != 0) begin
                item_t      it;
                logic [9:0] act;
                it  = sb_q.pop_front();
                act = {mode, drv_src, spi_en, reg_clear, reg_freeze, rst_status, uv_status};
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        step(3);
        expect_mode("R1 reset state", M_RST, 1'b0, 1'b0);
        rst_n = 1'b1;
        step(1); expect_mode("R3 reset to sleep1", M_SL1, 1'b0, 1'b0);
        din = 4'b0010;
        step(1); expect_mode("R3 sleep1 to reset", M_RST, 1'b0, 1'b0);
        din = 4'b0000;
        step(1); expect_mode("R3 reset to sleep1 again", M_SL1, 1'b0, 1'b0);
        din = 4'b0001; supply_ok = 1'b1;
        step(1); expect_mode("R3 R11 supply good to failsafe", M_FS, 1'b0, 1'b0);

        send(8'h00, 1'b0, 1'b0, 1'b1);
        expect_mode("R4 R12 no unlock stays failsafe", M_FS, 1'b1, 1'b0);
        send(8'h00, 1'b1, 1'b0, 1'b1);
        send(8'h00, 1'b0, 1'b0, 1'b1);
        expect_mode("R4 unlock then enable to normal", M_NRM, 1'b1, 1'b0);

        send(8'h00, 1'b1, 1'b0, 1'b1);
        send(8'h00, 1'b0, 1'b0, 1'b1);
        expect_mode("R5 intervening frame keeps normal", M_NRM, 1'b1, 1'b0);
        send(8'h00, 1'b0, 1'b1, 1'b0);
        expect_mode("R5 disarmed standby request falls to failsafe", M_FS, 1'b1, 1'b0);

        send(8'h00, 1'b1, 1'b0, 1'b1);
        send(8'h00, 1'b0, 1'b0, 1'b1);
        send(8'hFF, 1'b0, 1'b0, 1'b1);
        expect_mode("R7 soft reset clears", M_FS, 1'b0, 1'b1);
        step(1); expect_mode("R7 clear pulse one cycle", M_FS, 1'b0, 1'b0);

        send(8'h00, 1'b1, 1'b0, 1'b1);
        send(8'h00, 1'b0, 1'b0, 1'b1);
        send(8'h00, 1'b0, 1'b0, 1'b0);
        expect_mode("R7 enable cleared to failsafe", M_FS, 1'b1, 1'b0);

        send(8'h00, 1'b1, 1'b0, 1'b1);
        send(8'h00, 1'b0, 1'b0, 1'b1);
        step(TOG - 1); expect_mode("R8 before toggle timeout", M_NRM, 1'b1, 1'b0);
        step(1); expect_mode("R8 toggle timeout", M_FS, 1'b1, 1'b0);

        send(8'h00, 1'b1, 1'b0, 1'b1);
        send(8'h00, 1'b0, 1'b0, 1'b1);
        step(30); cs_n_raw = 1'b0; step(3); cs_n_raw = 1'b1; step(30);
        expect_mode("R8 toggles keep normal", M_NRM, 1'b1, 1'b0);
        step(45); expect_mode("R8 timeout after last toggle", M_FS, 1'b1, 1'b0);

        send(8'h00, 1'b1, 1'b0, 1'b0);
        send(8'h00, 1'b0, 1'b1, 1'b0);
        expect_mode("R6 failsafe to standby", M_STB, 1'b1, 1'b0);
        send(8'h00, 1'b1, 1'b0, 1'b1);
        send(8'h00, 1'b0, 1'b0, 1'b1);
        expect_mode("R13 frames ignored in standby", M_STB, 1'b1, 1'b0);
        send(8'hFF, 1'b0, 1'b0, 1'b0);
        expect_mode("R13 soft reset ignored in standby", M_STB, 1'b1, 1'b0);

        cs_n_raw = 1'b0; step(5); cs_n_raw = 1'b1; step(3);
        expect_mode("R9 short low pulse ignored", M_STB, 1'b1, 1'b0);
        din = 4'b0000;
        step(1); expect_mode("R9 standby to sleep2", M_SL2, 1'b1, 1'b0);
        din = 4'b1000;
        step(1); expect_mode("R9 sleep2 to standby", M_STB, 1'b1, 1'b0);
        din = 4'b0000;
        step(1); expect_mode("R9 back to sleep2", M_SL2, 1'b1, 1'b0);
        cs_n_raw = 1'b0;
        step(WAKE + 1); expect_mode("R9 before wake limit", M_SL2, 1'b1, 1'b0);
        step(1); expect_mode("R9 long low wakes to failsafe", M_FS, 1'b1, 1'b0);
        cs_n_raw = 1'b1; din = 4'b0101;

        send(8'h00, 1'b1, 1'b0, 1'b1);
        send(8'h00, 1'b0, 1'b0, 1'b1);
        send(8'h00, 1'b1, 1'b0, 1'b1);
        send(8'h00, 1'b0, 1'b1, 1'b0);
        expect_mode("R6 normal to standby", M_STB, 1'b1, 1'b0);
        cs_n_raw = 1'b0; step(20);
        expect_mode("R9 standby wakes to failsafe", M_FS, 1'b1, 1'b0);
        cs_n_raw = 1'b1;

        send(8'h00, 1'b1, 1'b0, 1'b1);
        send(8'h00, 1'b0, 1'b0, 1'b1);
        batt_uv = 1'b1;
        step(1); expect_mode("R10 undervoltage overlay", M_UV, 1'b1, 1'b0);
        send(8'hFF, 1'b1, 1'b0, 1'b0);
        expect_mode("R13 frames ignored in undervoltage", M_UV, 1'b1, 1'b0);
        batt_uv = 1'b0;
        step(1); expect_mode("R10 return to normal", M_NRM, 1'b1, 1'b0);

        supply_ok = 1'b0;
        step(1); expect_mode("R2 supply loss from normal", M_RST, 1'b0, 1'b0);
        supply_ok = 1'b1;
        step(1); expect_mode("R3 supply back to failsafe", M_FS, 1'b0, 1'b0);
        batt_uv = 1'b1;
        step(1); expect_mode("R10 overlay from failsafe", M_UV, 1'b0, 1'b0);
        supply_ok = 1'b0;
        step(1); expect_mode("R2 supply loss from undervoltage", M_RST, 1'b0, 1'b0);
        supply_ok = 1'b1;
        step(1); expect_mode("R3 reset to failsafe under batt low", M_FS, 1'b0, 1'b0);
        step(1); expect_mode("R10 overlay entered", M_UV, 1'b0, 1'b0);
        batt_uv = 1'b0;
        step(1); expect_mode("R10 return to failsafe", M_FS, 1'b0, 1'b0);

        step(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule